// File: doc/BRIEF.md
# Instruction Word Field Decoder

This block takes one 16-bit instruction word of a small microcontroller with sixteen registers and splits it into its fields. The register numbers are fixed: register 0 is the program counter, 1 is the stack pointer, 2 is the status register and 3 is the constant generator. The block sorts each word into one of three formats: two-operand, one-operand or conditional jump. For each format it reports the opcode, the register numbers, the addressing modes and the byte flag.

Some source pairings on registers 2 and 3 do not access a register. The block turns these into literal constants or into absolute addressing. It also works out how many extension words (0, 1 or 2) follow the instruction word in memory. The caller fetches those words; this block does not. The result is registered and appears one clock after a word is offered with `in_valid` high. Each offered word produces either a one-cycle valid pulse or a one-cycle illegal pulse.

Top module: `instr_field_decoder`

## Requirements
- R1: While reset is asserted, and at the first check after it is released, every output is zero.
- R2: A word whose bits [15:12] are 4 to 15 decodes as two-operand (format code 1). The outputs are: opcode = bits[15:12], source register = [11:8], destination mode = [7], byte = [6], source mode = [5:4], destination register = [3:0].
- R3: A word whose bits [15:10] are 000100 decodes as one-operand (format code 2). The outputs are: opcode = bits[9:7], byte = [6], source mode = [5:4], source register = [3:0]. Operation codes 6 and 7 are illegal.
- R4: A one-operand word with operation code 1, 3 or 5 and byte bit [6] set is illegal.
- R5: A word whose bits [15:13] are 001 decodes as a jump (format code 3). The opcode is the 3-bit condition in bits [12:10]. The offset output is bits [9:0] sign-extended to 16 bits.
- R6: With source register 3, source modes 0, 1, 2 and 3 give the constants 0, 1, 2 and all-ones. All-ones is 0xFFFF for a word operation and 0x00FF for a byte operation. The constant flag is set.
- R7: With source register 2, mode 2 gives the constant 4 and mode 3 gives the constant 8. Mode 1 sets the source-absolute flag.
- R8: With source mode 3 and a source register other than 0, 2 or 3, the post-increment step is 1 for a byte operation and 2 for a word operation. Otherwise the step is 0.
- R9: The extension-word count is the sum of two terms. The source term is 1 for mode 1 on any register except 3, and 1 for mode 3 on register 0. The destination term is 1 when a two-operand word has destination mode 1. A jump needs no extension word.
- R10: A two-operand word with destination mode 1 and destination register 2 sets the destination-absolute flag.
- R11: Each of these words asserts the illegal pulse and no valid pulse, and clears every decoded field to zero: bits [15:12] = 0; bits [15:12] = 1 with bits [11:10] nonzero; the illegal one-operand cases of R3 and R4.
- R12: A word offered with `in_valid` high shows its result one clock later. While `in_valid` is low, neither pulse is asserted and the decoded fields hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word is offered this cycle |
| in_word | input | 16 | Raw instruction word |
| out_valid | output | 1 | Legal word was decoded (one-cycle pulse) |
| out_illegal | output | 1 | Offered word matches no legal format (one-cycle pulse) |
| out_fmt | output | 2 | 0 none, 1 two-operand, 2 one-operand, 3 jump |
| out_opcode | output | 4 | Operation or jump condition |
| out_src_reg | output | 4 | Source (or sole operand) register |
| out_src_mode | output | 2 | Source addressing mode |
| out_dst_reg | output | 4 | Destination register |
| out_dst_mode | output | 1 | Destination addressing mode |
| out_byte | output | 1 | Byte operation |
| out_src_const | output | 1 | Source resolves to a literal constant |
| out_const_val | output | 16 | Value of that constant |
| out_src_abs | output | 1 | Source uses absolute addressing |
| out_dst_abs | output | 1 | Destination uses absolute addressing |
| out_inc_step | output | 2 | Post-increment step of the source register |
| out_ext_words | output | 2 | Extension words that follow |
| out_jump_off | output | 16 | Sign-extended jump word offset |

## Verification
Two things can land on the same decoded word: the source extension word and the destination extension word. A two-operand word with an absolute source and an absolute or indexed destination, such as 0x4292, must report a count of 2. It must also report both absolute flags together. Constant selection and the increment step compete for mode 3. The bench offers register 3 and register 2 in mode 3 next to ordinary registers, in both byte and word form. The behavioural model predicts every field of every cycle on its own, and any difference between the model and the outputs counts as a mismatch.

// File: rtl/ifd_pkg.sv
package ifd_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned REG_W  = 4;
  localparam int unsigned MODE_W = 2;
  localparam int unsigned OFF_W  = 10;
  localparam int unsigned EXT_W  = 2;

  localparam logic [REG_W-1:0] REG_PC = 4'd0;
  localparam logic [REG_W-1:0] REG_SR = 4'd2;
  localparam logic [REG_W-1:0] REG_CG = 4'd3;

  typedef enum logic [1:0] {
    FMT_NONE   = 2'd0,
    FMT_DOUBLE = 2'd1,
    FMT_SINGLE = 2'd2,
    FMT_JUMP   = 2'd3
  } fmt_e;

  // literal produced by the constant-generating register pairs
  function automatic logic [WORD_W-1:0] cg_literal(
      input logic [REG_W-1:0] r, input logic [MODE_W-1:0] m, input logic is_byte);
    logic [WORD_W-1:0] v;
    v = '0;
    if (r == REG_CG) begin
      case (m)
        2'd0: v = 16'd0;
        2'd1: v = 16'd1;
        2'd2: v = 16'd2;
        default: v = is_byte ? 16'h00FF : 16'hFFFF;
      endcase
    end else if (r == REG_SR) begin
      if (m == 2'd2) v = 16'd4;
      else if (m == 2'd3) v = 16'd8;
    end
    return v;
  endfunction

  function automatic logic cg_hit(input logic [REG_W-1:0] r, input logic [MODE_W-1:0] m);
    return (r == REG_CG) || (r == REG_SR && m[1]);
  endfunction
endpackage

// File: rtl/ifd_format_classifier.sv
module ifd_format_classifier
  import ifd_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output fmt_e              fmt,
  output logic              legal
);
  logic [2:0] one_op;
  logic       one_op_ok;

  assign one_op    = word[9:7];
  // operation codes 1, 3, 5 have no byte form; 6 and 7 are unassigned
  assign one_op_ok = (one_op <= 3'd5) && !(one_op[0] && word[6]);

  always_comb begin
    fmt   = FMT_NONE;
    legal = 1'b0;
    if (word[15:14] != 2'b00) begin
      fmt   = FMT_DOUBLE;
      legal = 1'b1;
    end else if (word[15:13] == 3'b001) begin
      fmt   = FMT_JUMP;
      legal = 1'b1;
    end else if (word[15:10] == 6'b000100 && one_op_ok) begin
      fmt   = FMT_SINGLE;
      legal = 1'b1;
    end
  end
endmodule

// File: rtl/ifd_src_resolver.sv
module ifd_src_resolver
  import ifd_pkg::*;
(
  input  logic [REG_W-1:0]  src_reg,
  input  logic [MODE_W-1:0] src_mode,
  input  logic              is_byte,
  input  logic              used,
  output logic              is_const,
  output logic [WORD_W-1:0] const_val,
  output logic              is_abs,
  output logic              need_ext,
  output logic [1:0]        inc_step
);
  logic hit;
  assign hit       = used && cg_hit(src_reg, src_mode);
  assign is_const  = hit;
  assign const_val = hit ? cg_literal(src_reg, src_mode, is_byte) : '0;
  assign is_abs    = used && (src_reg == REG_SR) && (src_mode == 2'd1);
  assign need_ext  = used && (((src_mode == 2'd1) && (src_reg != REG_CG)) ||
                              ((src_mode == 2'd3) && (src_reg == REG_PC)));
  assign inc_step  = (used && src_mode == 2'd3 && !hit && src_reg != REG_PC)
                     ? (is_byte ? 2'd1 : 2'd2) : 2'd0;
endmodule

// File: rtl/instr_field_decoder.sv
module instr_field_decoder
  import ifd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [15:0] in_word,
  output logic        out_valid,
  output logic        out_illegal,
  output logic [1:0]  out_fmt,
  output logic [3:0]  out_opcode,
  output logic [3:0]  out_src_reg,
  output logic [1:0]  out_src_mode,
  output logic [3:0]  out_dst_reg,
  output logic        out_dst_mode,
  output logic        out_byte,
  output logic        out_src_const,
  output logic [15:0] out_const_val,
  output logic        out_src_abs,
  output logic        out_dst_abs,
  output logic [1:0]  out_inc_step,
  output logic [1:0]  out_ext_words,
  output logic [15:0] out_jump_off
);
  fmt_e              fmt_w;
  logic              legal_w;
  logic [3:0]        opc_w, sreg_w, dreg_w;
  logic [1:0]        smode_w;
  logic              dmode_w, byte_w, src_used_w;
  logic              cst_w, sabs_w, sext_w;
  logic [15:0]       cval_w;
  logic [1:0]        step_w;
  logic              dabs_w, dext_w;
  logic [1:0]        ext_w;
  logic [15:0]       joff_w;

  ifd_format_classifier u_cls (
    .word (in_word),
    .fmt  (fmt_w),
    .legal(legal_w)
  );

  always_comb begin
    opc_w   = '0;
    sreg_w  = '0;
    dreg_w  = '0;
    smode_w = '0;
    dmode_w = 1'b0;
    byte_w  = 1'b0;
    joff_w  = '0;
    unique case (fmt_w)
      FMT_DOUBLE: begin
        opc_w   = in_word[15:12];
        sreg_w  = in_word[11:8];
        dmode_w = in_word[7];
        byte_w  = in_word[6];
        smode_w = in_word[5:4];
        dreg_w  = in_word[3:0];
      end
      FMT_SINGLE: begin
        opc_w   = {1'b0, in_word[9:7]};
        byte_w  = in_word[6];
        smode_w = in_word[5:4];
        sreg_w  = in_word[3:0];
      end
      FMT_JUMP: begin
        opc_w  = {1'b0, in_word[12:10]};
        joff_w = {{(WORD_W-OFF_W){in_word[OFF_W-1]}}, in_word[OFF_W-1:0]};
      end
      default: ;
    endcase
  end

  assign src_used_w = (fmt_w == FMT_DOUBLE) || (fmt_w == FMT_SINGLE);

  ifd_src_resolver u_src (
    .src_reg  (sreg_w),
    .src_mode (smode_w),
    .is_byte  (byte_w),
    .used     (src_used_w),
    .is_const (cst_w),
    .const_val(cval_w),
    .is_abs   (sabs_w),
    .need_ext (sext_w),
    .inc_step (step_w)
  );

  assign dext_w = (fmt_w == FMT_DOUBLE) && dmode_w;
  assign dabs_w = dext_w && (dreg_w == REG_SR);
  assign ext_w  = {1'b0, sext_w} + {1'b0, dext_w};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_illegal   <= 1'b0;
      out_fmt       <= '0;
      out_opcode    <= '0;
      out_src_reg   <= '0;
      out_src_mode  <= '0;
      out_dst_reg   <= '0;
      out_dst_mode  <= 1'b0;
      out_byte      <= 1'b0;
      out_src_const <= 1'b0;
      out_const_val <= '0;
      out_src_abs   <= 1'b0;
      out_dst_abs   <= 1'b0;
      out_inc_step  <= '0;
      out_ext_words <= '0;
      out_jump_off  <= '0;
    end else begin
      out_valid   <= in_valid && legal_w;
      out_illegal <= in_valid && !legal_w;
      if (in_valid) begin
        out_fmt       <= fmt_w;
        out_opcode    <= opc_w;
        out_src_reg   <= sreg_w;
        out_src_mode  <= smode_w;
        out_dst_reg   <= dreg_w;
        out_dst_mode  <= dmode_w;
        out_byte      <= byte_w;
        out_src_const <= cst_w;
        out_const_val <= cval_w;
        out_src_abs   <= sabs_w;
        out_dst_abs   <= dabs_w;
        out_inc_step  <= step_w;
        out_ext_words <= ext_w;
        out_jump_off  <= joff_w;
      end
    end
  end

  // R11
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && out_illegal));
  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !out_illegal));
  // R11
  low_range_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_word[15:12] == 4'h0) |=> (out_illegal && out_fmt == 2'd0));
  // R9
  jump_no_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_fmt == 2'd3) |-> (out_ext_words == 2'd0));
  // R6
  cg_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_fmt != 2'd3 && out_src_reg == 4'd3) |-> out_src_const);
  // R8
  step_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_inc_step != 2'd0) |-> (out_src_mode == 2'd3 && !out_src_const));
endmodule

// File: tb/sim_instr_field_decoder.sv
module sim_instr_field_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_word = '0;
  logic        out_valid, out_illegal, out_dst_mode, out_byte;
  logic        out_src_const, out_src_abs, out_dst_abs;
  logic [1:0]  out_fmt, out_src_mode, out_inc_step, out_ext_words;
  logic [3:0]  out_opcode, out_src_reg, out_dst_reg;
  logic [15:0] out_const_val, out_jump_off;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  instr_field_decoder u0 (.*);

  // expected state (model)
  int e_val, e_ill, e_fmt, e_opc, e_sreg, e_smode, e_dreg, e_dmode, e_byte;
  int e_cst, e_cval, e_sabs, e_dabs, e_step, e_ext, e_joff;

  task automatic chk(input string req, input string nm, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, nm, act, exp, cyc);
    end
  endtask

  task automatic model_clear();
    {e_val, e_ill, e_fmt, e_opc, e_sreg, e_smode, e_dreg, e_dmode} = '0;
    {e_byte, e_cst, e_cval, e_sabs, e_dabs, e_step, e_ext, e_joff} = '0;
  endtask

  task automatic model_step(input bit v, input int w);
    int top4, op1, srcterm, dstterm;
    e_val = 0; e_ill = 0;
    if (!v) return;
    top4 = (w >> 12) & 15;
    e_fmt = 0; e_opc = 0; e_sreg = 0; e_smode = 0; e_dreg = 0; e_dmode = 0;
    e_byte = 0; e_cst = 0; e_cval = 0; e_sabs = 0; e_dabs = 0; e_step = 0;
    e_ext = 0; e_joff = 0;
    if (top4 >= 4) e_fmt = 1;
    else if (top4 == 2 || top4 == 3) e_fmt = 3;
    else if (((w >> 10) & 63) == 4) begin
      op1 = (w >> 7) & 7;
      if (op1 <= 5 && !((op1 == 1 || op1 == 3 || op1 == 5) && ((w >> 6) & 1))) e_fmt = 2;
    end
    if (e_fmt == 0) begin e_ill = 1; return; end
    e_val = 1;
    if (e_fmt == 3) begin
      e_opc = (w >> 10) & 7;
      e_joff = w & 1023;
      if (e_joff >= 512) e_joff = e_joff + 16'hFC00;
      return;
    end
    e_byte = (w >> 6) & 1;
    e_smode = (w >> 4) & 3;
    if (e_fmt == 1) begin
      e_opc = top4; e_sreg = (w >> 8) & 15; e_dmode = (w >> 7) & 1; e_dreg = w & 15;
    end else begin
      e_opc = (w >> 7) & 7; e_sreg = w & 15;
    end
    if (e_sreg == 3) begin
      e_cst = 1;
      e_cval = (e_smode == 3) ? (e_byte ? 255 : 65535) : e_smode;
    end else if (e_sreg == 2 && e_smode >= 2) begin
      e_cst = 1; e_cval = (e_smode == 2) ? 4 : 8;
    end
    e_sabs = (e_sreg == 2 && e_smode == 1);
    srcterm = ((e_smode == 1 && e_sreg != 3) || (e_smode == 3 && e_sreg == 0)) ? 1 : 0;
    dstterm = (e_fmt == 1 && e_dmode == 1) ? 1 : 0;
    e_ext = srcterm + dstterm;
    e_dabs = (dstterm == 1 && e_dreg == 2);
    if (e_smode == 3 && !e_cst && e_sreg != 0) e_step = e_byte ? 1 : 2;
  endtask

  task automatic compare_all();
    chk("R12", "valid", out_valid, e_val);
    chk("R11", "illegal", out_illegal, e_ill);
    chk("R2", "fmt", out_fmt, e_fmt);
    chk("R3", "opcode", out_opcode, e_opc);
    chk("R2", "src_reg", out_src_reg, e_sreg);
    chk("R3", "src_mode", out_src_mode, e_smode);
    chk("R2", "dst_reg", out_dst_reg, e_dreg);
    chk("R2", "dst_mode", out_dst_mode, e_dmode);
    chk("R4", "byte", out_byte, e_byte);
    chk("R6", "const", out_src_const, e_cst);
    chk("R6", "const_val", out_const_val, e_cval);
    chk("R7", "src_abs", out_src_abs, e_sabs);
    chk("R10", "dst_abs", out_dst_abs, e_dabs);
    chk("R8", "inc_step", out_inc_step, e_step);
    chk("R9", "ext_words", out_ext_words, e_ext);
    chk("R5", "jump_off", out_jump_off, e_joff);
  endtask

  task automatic offer(input bit v, input int w);
    in_valid = v;
    in_word  = w[15:0];
    model_step(v, w);
    @(negedge clk);
    cyc++;
    compare_all();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : stim
    int dir [] = '{
      'h4292, 'h4303, 'h4313, 'h4323, 'h4333, 'h4373, 'h4222, 'h4232,
      'h4035, 'h4536, 'h4576, 'h4C2E, 'h5A9B, 'h1035, 'h1075, 'h10C4,
      'h10F3, 'h1094, 'h11A5, 'h12B0, 'h1230, 'h1322, 'h1380, 'h1400,
      'h0000, 'h0FFF, 'h1C00, 'h2000, 'h23FF, 'h3E00, 'h3DFF, 'hF0D2,
      'h4392, 'h4212};
    model_clear();
    repeat (3) @(negedge clk);
    // R1: reset state
    compare_all();
    rst_n = 1'b1;
    @(negedge clk);
    cyc++;
    compare_all();
    foreach (dir[i]) offer(1'b1, dir[i]);
    offer(1'b0, 'h4292);   // R12: idle hold
    offer(1'b0, 'h0000);
    for (int k = 0; k < 3000; k++) begin
      bit v;
      v = ($urandom % 8) != 0;
      offer(v, int'($urandom & 32'hFFFF));
    end
    // back-to-back idle after an illegal word
    offer(1'b1, 'h0123);
    offer(1'b0, 'h4000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule